// File: doc/BRIEF.md
# Race-free shared output and interrupt register bank

This block is a small memory-mapped register file for a shared output port, a set of hardware event flags and a 64-line interrupt mask. Several software agents can own different bits of the same register. None of them needs a read-modify-write sequence to change its own bits, so none of them can overwrite bits that another agent changed in the meantime.

Each piece of shared state has a write path that touches only the bits named in the written word. The output latch has a plain write port and an XOR port. The event flags are cleared by writing ones. The interrupt mask can be written as two bitmap words, or one line at a time through a set port and a clear port that take the line number.

The bus is word-addressed and accepts one write per clock, qualified by byte lanes. Reads are combinational.

Top module: `atomic_regbank`

## Requirements
- R1: After reset, the output latch, the event flags and the interrupt mask are all zero.
- R2: A write to address 0 replaces only the latch bytes whose lane bit is 1; `bus_be[k]` governs bits 8k+7..8k.
- R3: A write to address 1 XORs the written data, restricted to the enabled lanes, into the latch. Bits written as 0 keep their value, so two agents that flip disjoint pins never disturb each other.
- R4: A 1 on `evt_in[i]` in any cycle sets flag i, and the flag holds until cleared. A write to address 2 clears the flags whose written bit is 1 in an enabled lane. All other flags are untouched.
- R5: When an event and a clear hit the same flag in the same cycle, the flag ends set.
- R6: Addresses 3 and 4 write mask lines 31..0 and 63..32 respectively, with the same byte-lane rule as R2.
- R7: Writing N (0..63) to address 5 sets mask line N and leaves every other line unchanged. This is the same result as ORing a one-hot word into the bitmap.
- R8: Writing N (0..63) to address 6 clears mask line N and leaves every other line unchanged.
- R9: A write of a value of 64 or more to address 5 or 6 leaves the mask unchanged.
- R10: A read returns the following in the same cycle: the latch at addresses 0 and 1, the live flags at address 2, mask lines 31..0 at addresses 3 and 5, and mask lines 63..32 at addresses 4 and 6. Any other address reads zero.
- R11: The index ports and the bitmap words act on the same mask storage. A line set by number is visible in the bitmap word and on `irq_mask`, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_in | input | 32 | Hardware event pulses, one per flag |
| pin_out | output | 32 | Output latch |
| irq_mask | output | 64 | Interrupt mask, one bit per line |

## Verification
Directed writes use partial byte lanes, so that a lane-decoding error shows up as a wrong neighbouring byte. Two successive flips on disjoint nibbles separate a true XOR from a plain overwrite. An event and a clear on the same flag in the same cycle checks R5, the priority rule. Indices 63, 64 and 256 fix the range edge of the set and clear ports.

A long seeded random run then mixes every address, random lanes and sparse random events on every cycle. Against a bench model, this run exposes any cross-talk between the index ports and the bitmap words, and any alias that reads back the wrong word.

// File: rtl/atomic_regbank_pkg.sv
package atomic_regbank_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = WORD_W / 8;
  localparam int unsigned LINES  = 2 * WORD_W;
  localparam int unsigned IDX_W  = $clog2(LINES);

  typedef enum logic [2:0] {
    SEL_OUT  = 3'd0,
    SEL_FLIP = 3'd1,
    SEL_EVT  = 3'd2,
    SEL_MLO  = 3'd3,
    SEL_MHI  = 3'd4,
    SEL_MSET = 3'd5,
    SEL_MCLR = 3'd6
  } reg_sel_e;

  // expand byte-lane enables to a bit mask
  function automatic logic [WORD_W-1:0] lane_bits(input logic [LANE_W-1:0] be);
    logic [WORD_W-1:0] m;
    for (int k = 0; k < int'(LANE_W); k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction

  // replace the masked bits of old with new data
  function automatic logic [WORD_W-1:0] merge_bits(input logic [WORD_W-1:0] old,
                                                   input logic [WORD_W-1:0] nw,
                                                   input logic [WORD_W-1:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  // index in range check: all bits above the index field are zero
  function automatic logic index_ok(input logic [WORD_W-1:0] v);
    return (v >> IDX_W) == '0;
  endfunction

  // one-hot line word for an index, zero when out of range
  function automatic logic [LINES-1:0] line_hot(input logic [WORD_W-1:0] v);
    logic [LINES-1:0] h;
    h = '0;
    if (index_ok(v)) h[v[IDX_W-1:0]] = 1'b1;
    return h;
  endfunction
endpackage

// File: rtl/regbank_out_latch.sv
module regbank_out_latch
  import atomic_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_direct,
  input  logic              wr_flip,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] lanes,
  output logic [WORD_W-1:0] pin_q
);
  logic [WORD_W-1:0] flip_bits;
  logic [WORD_W-1:0] pin_d;

  assign flip_bits = wdata & lanes;

  always_comb begin
    pin_d = pin_q;
    if (wr_direct)    pin_d = merge_bits(pin_q, wdata, lanes);
    else if (wr_flip) pin_d = pin_q ^ flip_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  // R2: disabled lanes keep their value on a direct write
  assert_lane_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_direct |=> ((pin_q ^ $past(pin_q)) & ~$past(lanes)) == '0);

  // R3: a flip changes exactly the bits written as one
  assert_flip_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flip |=> (pin_q ^ $past(pin_q)) == $past(wdata & lanes));
endmodule

// File: rtl/regbank_evt_status.sv
module regbank_evt_status
  import atomic_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_clear,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] lanes,
  input  logic [WORD_W-1:0] evt_in,
  output logic [WORD_W-1:0] stat_q
);
  logic [WORD_W-1:0] clr_bits;
  logic              past_ok;

  assign clr_bits = wr_clear ? (wdata & lanes) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~clr_bits) | evt_in;
      past_ok <= 1'b1;
    end
  end

  // R5: an event in the previous cycle always leaves its flag set
  assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (stat_q & $past(evt_in)) == $past(evt_in));

  // R4: set flags not named by the clear stay set
  assert_w1c_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> (($past(stat_q) & ~$past(clr_bits)) & ~stat_q) == '0);
endmodule

// File: rtl/regbank_irq_mask.sv
module regbank_irq_mask
  import atomic_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] lanes,
  output logic [LINES-1:0]  mask_q
);
  logic [LINES-1:0] hot;
  logic             idx_good;
  logic [LINES-1:0] mask_d;

  assign hot      = line_hot(wdata);
  assign idx_good = index_ok(wdata);

  always_comb begin
    mask_d = mask_q;
    if (wr_lo)       mask_d[WORD_W-1:0]      = merge_bits(mask_q[WORD_W-1:0], wdata, lanes);
    else if (wr_hi)  mask_d[LINES-1:WORD_W]  = merge_bits(mask_q[LINES-1:WORD_W], wdata, lanes);
    else if (wr_set) mask_d                  = mask_q | hot;
    else if (wr_clr) mask_d                  = mask_q & ~hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R7: set by number raises that line and nothing else
  assert_set_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && idx_good) |=> mask_q[$past(wdata[IDX_W-1:0])] &&
      ((mask_q ^ $past(mask_q)) & ~$past(hot)) == '0);

  // R8: clear by number drops that line
  assert_clr_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && idx_good) |=> !mask_q[$past(wdata[IDX_W-1:0])]);

  // R9: out-of-range numbers leave the mask alone
  assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_set || wr_clr) && !idx_good) |=> $stable(mask_q));
endmodule

// File: rtl/atomic_regbank.sv
module atomic_regbank
  import atomic_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_in,
  output logic [31:0]       pin_out,
  output logic [63:0]       irq_mask
);
  logic [WORD_W-1:0] lanes;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] pin_q;
  logic [LINES-1:0]  mask_q;
  logic wr_out, wr_flip, wr_evt, wr_mlo, wr_mhi, wr_mset, wr_mclr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e s);
    return a == ADDR_W'(s);
  endfunction

  assign lanes   = lane_bits(bus_be);
  assign wr_out  = bus_we && hit(bus_addr, SEL_OUT);
  assign wr_flip = bus_we && hit(bus_addr, SEL_FLIP);
  assign wr_evt  = bus_we && hit(bus_addr, SEL_EVT);
  assign wr_mlo  = bus_we && hit(bus_addr, SEL_MLO);
  assign wr_mhi  = bus_we && hit(bus_addr, SEL_MHI);
  assign wr_mset = bus_we && hit(bus_addr, SEL_MSET);
  assign wr_mclr = bus_we && hit(bus_addr, SEL_MCLR);

  regbank_out_latch u_out (
    .clk(clk), .rst_n(rst_n), .wr_direct(wr_out), .wr_flip(wr_flip),
    .wdata(bus_wdata), .lanes(lanes), .pin_q(pin_q)
  );

  regbank_evt_status u_evt (
    .clk(clk), .rst_n(rst_n), .wr_clear(wr_evt), .wdata(bus_wdata),
    .lanes(lanes), .evt_in(evt_in), .stat_q(stat_q)
  );

  regbank_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_mlo), .wr_hi(wr_mhi),
    .wr_set(wr_mset), .wr_clr(wr_mclr), .wdata(bus_wdata),
    .lanes(lanes), .mask_q(mask_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, SEL_OUT) || hit(bus_addr, SEL_FLIP))      bus_rdata = pin_q;
    else if (hit(bus_addr, SEL_EVT))                            bus_rdata = stat_q;
    else if (hit(bus_addr, SEL_MLO) || hit(bus_addr, SEL_MSET)) bus_rdata = mask_q[WORD_W-1:0];
    else if (hit(bus_addr, SEL_MHI) || hit(bus_addr, SEL_MCLR)) bus_rdata = mask_q[LINES-1:WORD_W];
  end

  assign pin_out  = pin_q;
  assign irq_mask = mask_q;

  // R1: state is zero in the first cycle after reset release
  assert_reset_zero_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_out == '0 && irq_mask == '0));

  // R11: the bitmap words always mirror the mask port
  always_comb begin
    if (rst_n && !bus_we && hit(bus_addr, SEL_MHI))
      assert_shared_store_R11: assert (bus_rdata == irq_mask[63:32]);
  end
endmodule

// File: tb/atomic_regbank_tb.sv
module atomic_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_in = '0;
  logic [31:0] pin_out;
  logic [63:0] irq_mask;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pin = '0;
  logic [31:0] m_stat = '0;
  logic [63:0] m_mask = '0;

  always #4 clk = ~clk;

  atomic_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .pin_out(pin_out), .irq_mask(irq_mask)
  );

  function automatic logic [31:0] f_lanes(input logic [3:0] be);
    logic [31:0] r = '0;
    if (be[0]) r |= 32'h0000_00FF;
    if (be[1]) r |= 32'h0000_FF00;
    if (be[2]) r |= 32'h00FF_0000;
    if (be[3]) r |= 32'hFF00_0000;
    return r;
  endfunction

  function automatic logic [63:0] f_line(input logic [31:0] n);
    return (n < 32'd64) ? (64'd1 << n) : 64'd0;
  endfunction

  function automatic logic [31:0] f_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return m_pin;
      3'd2:       return m_stat;
      3'd3, 3'd5: return m_mask[31:0];
      3'd4, 3'd6: return m_mask[63:32];
      default:    return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional write plus events; model updated alongside
  task automatic op(input logic we, input logic [2:0] a, input logic [31:0] d,
                    input logic [3:0] be, input logic [31:0] ev);
    logic [31:0] lm;
    @(posedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be; evt_in = ev;
    @(posedge clk); #1;
    bus_we = 1'b0; evt_in = '0;
    lm = f_lanes(be);
    if (we) begin
      case (a)
        3'd0: m_pin = (m_pin & ~lm) | (d & lm);
        3'd1: m_pin = m_pin ^ (d & lm);
        3'd2: m_stat = m_stat & ~(d & lm);
        3'd3: m_mask[31:0] = (m_mask[31:0] & ~lm) | (d & lm);
        3'd4: m_mask[63:32] = (m_mask[63:32] & ~lm) | (d & lm);
        3'd5: m_mask = m_mask | f_line(d);
        3'd6: m_mask = m_mask & ~f_line(d);
        default: ;
      endcase
    end
    m_stat = m_stat | ev;
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    bus_addr = a; #1;
    chk(req, {32'd0, bus_rdata}, {32'd0, f_read(a)});
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pins", {32'd0, pin_out}, 64'd0);
    chk("R1 mask", irq_mask, 64'd0);
    rd("R1 flags", 3'd2);
    rst_n = 1'b1;

    op(1, 3'd0, 32'hFFFF_FFFF, 4'b0101, 0);
    chk("R2 lanes", {32'd0, pin_out}, 64'h00FF_00FF);
    op(1, 3'd1, 32'h0000_000F, 4'hF, 0);
    op(1, 3'd1, 32'h0000_0F00, 4'hF, 0);
    chk("R3 disjoint flips", {32'd0, pin_out}, {32'd0, m_pin});
    op(1, 3'd1, 32'hFFFF_FFFF, 4'b1000, 0);
    chk("R3 flip lane", {32'd0, pin_out}, {32'd0, m_pin});

    op(0, 3'd0, 0, 0, 32'h0000_0005);
    rd("R4 flags set", 3'd2);
    op(1, 3'd2, 32'h0000_0001, 4'hF, 0);
    rd("R4 w1c one bit", 3'd2);
    op(1, 3'd2, 32'h0000_0004, 4'hF, 32'h0000_0004);
    rd("R5 event wins", 3'd2);
    chk("R5 model", {32'd0, m_stat}, 64'h4);

    op(1, 3'd3, 32'hA5A5_A5A5, 4'b0011, 0);
    op(1, 3'd4, 32'h1234_5678, 4'b1100, 0);
    chk("R6 bitmap", irq_mask, m_mask);
    op(1, 3'd5, 32'd40, 4'hF, 0);
    chk("R7 set 40", irq_mask, m_mask);
    op(1, 3'd5, 32'd63, 4'hF, 0);
    rd("R11 set seen in bitmap", 3'd4);
    op(1, 3'd6, 32'd40, 4'hF, 0);
    chk("R8 clr 40", irq_mask, m_mask);
    op(1, 3'd5, 32'd64, 4'hF, 0);
    op(1, 3'd6, 32'd256 + 32'd63, 4'hF, 0);
    chk("R9 out of range", irq_mask, m_mask);
    op(1, 3'd4, 32'd0, 4'hF, 0);
    op(1, 3'd6, 32'd0, 4'hF, 0);
    chk("R11 bitmap clears lines", irq_mask, m_mask);
    for (int a = 0; a < 8; a++) rd("R10 read map", 3'(a));

    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom_range(0, 7));
      d = (a >= 3'd5 && $urandom_range(0, 3) != 0) ? 32'($urandom_range(0, 70)) : $urandom;
      op(1'($urandom_range(0, 1)), a, d, 4'($urandom), $urandom & $urandom & $urandom);
      chk("R3 random pins", {32'd0, pin_out}, {32'd0, m_pin});
      chk("R7 random mask", irq_mask, m_mask);
      rd("R10 random read", 3'($urandom_range(0, 7)));
      rd("R4 random flags", 3'd2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule